// File: doc/BRIEF.md
# Serial Channel Baud Divider Register

This block is the per-channel data and clock-divide word of a serial channel, together with the transfer-clock divider that the word programs. A single 16-bit word holds two things. Its low byte is the transmit/receive buffer, which a shifter outside this block uses through a dedicated byte output. Its top seven bits hold a divide code. Bit 8 is reserved and always reads as zero.

When the channel runs with the internal clock selected, the divider turns the operating clock into a one-cycle transfer-clock strobe. The strobe repeats every 2×(code+1) operating-clock cycles. While the channel is enabled, the divide code is locked against writes and reads back as zero. The low byte stays fully accessible. A code that the selected line mode does not allow raises a sticky error. The divider then runs at the smallest ratio that mode allows.

Top module: `ser_baud_top`

## Requirements
- R1: After reset, the read word is 0000H, the buffer byte is 00H, the error flag is 0 and the strobe is 0.
- R2: Bit 8 of the read word is always 0, even after a write with bit 8 set.
- R3: With the channel enabled, internal clock selected (clk_sel_i = 0) and a mode with no restriction, the strobe is high for exactly one cycle every 2×(code+1) cycles, where code is bits 15:9 of the word.
- R4: With clk_sel_i = 1, the strobe never goes high.
- R5: While chan_en_i = 0, a write stores bits 15:9 and bits 7:0, and a read returns them unchanged.
- R6: While chan_en_i = 1, a write updates only bits 7:0. The code written earlier reads back once the channel is disabled.
- R7: While chan_en_i = 1, bits 15:9 of the read word are 0 and bits 7:0 show the buffer.
- R8: buf_o always equals bits 7:0 of the stored word.
- R9: The divider reloads when the channel goes from disabled to enabled. Take the first clock edge that samples chan_en_i high. The first strobe appears 2×(code+1) cycles after that edge, and no strobe comes before it.
- R10: mode_i encodes 01 = UART and 10 = simplified I2C; 00 and 11 carry no restriction. Codes 0 and 1 are prohibited in UART mode, and code 0 in I2C mode. If an enabled channel samples a prohibited code, err_o rises one cycle later and stays high until reset. The period is then clamped to 6 cycles (UART) or 4 cycles (I2C). Legal codes never raise err_o.
- R11: A change of the effective ratio during a running period takes effect only at the next reload, which happens on a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Operating clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the 16-bit word |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, under the access rules |
| chan_en_i | input | 1 | Channel running |
| clk_sel_i | input | 1 | 0 selects the internal divider, 1 leaves it unused |
| mode_i | input | 2 | Line mode: 01 UART, 10 simplified I2C, others unrestricted |
| buf_o | output | 8 | Buffer byte toward the shifter |
| tclk_stb_o | output | 1 | One-cycle transfer-clock strobe |
| err_o | output | 1 | Sticky prohibited-code flag |

## Verification
The hardest case to reach is a ratio change while a period is running. The code cannot change then, because it is locked while the channel is enabled, so only a mode switch can change the effective ratio mid-period. To reach it, the stimulus enables the channel in UART mode with the prohibited code 0. It then switches to an unrestricted mode halfway through the first period. The bench expects the first strobe at the clamped 6-cycle point, and the next one only 2 cycles after that. A hidden code is checked by writing a new byte while the channel is enabled, then disabling the channel and reading the old code back.

// File: rtl/ser_baud_pkg.sv
package ser_baud_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned CODE_W = 7;
    localparam int unsigned WORD_W = DATA_W + 1 + CODE_W;
    localparam int unsigned CNT_W  = CODE_W + 1;

    localparam logic [CODE_W-1:0] UART_MIN_CODE = CODE_W'(2);
    localparam logic [CODE_W-1:0] I2C_MIN_CODE  = CODE_W'(1);

    typedef enum logic [1:0] {
        LINE_PLAIN = 2'b00,
        LINE_UART  = 2'b01,
        LINE_I2C   = 2'b10,
        LINE_ALT   = 2'b11
    } line_mode_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] data;
    } word_st_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] lat;
        logic              run;
    } div_st_t;

    function automatic logic [CODE_W-1:0] min_code(input line_mode_e m);
        case (m)
            LINE_UART: return UART_MIN_CODE;
            LINE_I2C:  return I2C_MIN_CODE;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/ser_baud_word.sv
module ser_baud_word
    import ser_baud_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              chan_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [CODE_W-1:0] code_o,
    output logic [DATA_W-1:0] data_o
);

    word_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.data = wr_data_i[DATA_W-1:0];
            if (!chan_en_i) begin
                st_d.code = wr_data_i[WORD_W-1:DATA_W+1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = {(chan_en_i ? {CODE_W{1'b0}} : st_q.code), 1'b0, st_q.data};
    end

    assign code_o = st_q.code;
    assign data_o = st_q.data;

    // R6: an enabled channel never changes its stored code
    p_code_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chan_en_i |=> $stable(st_q.code));

    // R2: reserved bit reads as zero
    p_bit8_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[DATA_W] == 1'b0);

endmodule

// File: rtl/ser_baud_legal.sv
module ser_baud_legal
    import ser_baud_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        mode_i,
    input  logic              chan_en_i,
    output logic [CODE_W-1:0] eff_code_o,
    output logic              err_o
);

    logic [CODE_W-1:0] floor_c;
    logic              bad_c;
    logic              err_d, err_q;

    always_comb begin
        floor_c    = min_code(line_mode_e'(mode_i));
        bad_c      = (code_i < floor_c);
        eff_code_o = bad_c ? floor_c : code_i;
        err_d      = err_q | (chan_en_i & bad_c);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_o = err_q;

    // R10: error flag is sticky until reset
    p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_q |=> err_q);

    // R10: clamped ratio never below the mode floor
    p_eff_floor_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eff_code_o >= floor_c);

endmodule

// File: rtl/ser_baud_div.sv
module ser_baud_div
    import ser_baud_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              chan_en_i,
    input  logic              clk_sel_i,
    input  logic [CODE_W-1:0] eff_code_i,
    output logic              tclk_stb_o
);

    div_st_t st_d, st_q;
    logic    start_c;
    logic    wrap_c;

    always_comb begin
        st_d    = st_q;
        start_c = chan_en_i && !st_q.run;
        wrap_c  = (st_q.cnt == '0);
        st_d.run = chan_en_i;
        if (start_c || (chan_en_i && wrap_c)) begin
            st_d.cnt = {eff_code_i, 1'b1};
            st_d.lat = eff_code_i;
        end else if (chan_en_i) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        tclk_stb_o = st_q.run && chan_en_i && !clk_sel_i && wrap_c;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the strobe is one cycle wide
    p_stb_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tclk_stb_o |=> !tclk_stb_o);

    // R9: no strobe in the cycle right after the enabling edge
    p_no_early_stb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chan_en_i && !st_q.run) |=> !tclk_stb_o);

    // R11: the counter never exceeds the period latched at the last reload
    p_cnt_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.run |-> (st_q.cnt <= {st_q.lat, 1'b1}));

endmodule

// File: rtl/ser_baud_top.sv
module ser_baud_top
    import ser_baud_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              chan_en_i,
    input  logic              clk_sel_i,
    input  logic [1:0]        mode_i,
    output logic [DATA_W-1:0] buf_o,
    output logic              tclk_stb_o,
    output logic              err_o
);

    logic [CODE_W-1:0] code_w;
    logic [CODE_W-1:0] eff_w;

    ser_baud_word u_word (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .chan_en_i (chan_en_i),
        .rd_data_o (rd_data_o),
        .code_o    (code_w),
        .data_o    (buf_o)
    );

    ser_baud_legal u_legal (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .code_i     (code_w),
        .mode_i     (mode_i),
        .chan_en_i  (chan_en_i),
        .eff_code_o (eff_w),
        .err_o      (err_o)
    );

    ser_baud_div u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .chan_en_i  (chan_en_i),
        .clk_sel_i  (clk_sel_i),
        .eff_code_i (eff_w),
        .tclk_stb_o (tclk_stb_o)
    );

    // R7: the code field is hidden while running
    p_hidden_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chan_en_i |-> (rd_data_o[WORD_W-1:DATA_W+1] == '0));

    // R4: an external clock selection silences the strobe
    p_ext_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_sel_i |-> !tclk_stb_o);

endmodule

// File: tb/ser_baud_top_tb_top.sv
module ser_baud_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        chan_en;
    logic        clk_sel;
    logic [1:0]  mode;
    logic [7:0]  buf_b;
    logic        stb;
    logic        err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ser_baud_top dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .chan_en_i  (chan_en),
        .clk_sel_i  (clk_sel),
        .mode_i     (mode),
        .buf_o      (buf_b),
        .tclk_stb_o (stb),
        .err_o      (err)
    );

    function automatic int exp_period(input int code, input logic [1:0] m);
        int e;
        e = code;
        if (m == 2'b01 && e < 2) e = 2;
        if (m == 2'b10 && e < 1) e = 1;
        return 2 * (e + 1);
    endfunction

    function automatic logic [15:0] exp_read(input logic [6:0] c, input logic [7:0] d,
                                             input logic en);
        return {(en ? 7'd0 : c), 1'b0, d};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; chan_en = 1'b0;
        clk_sel = 1'b0; mode = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_word(input logic [15:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called right after chan_en rises at a negedge
    task automatic watch(input int p, input int cycles, input string req);
        for (int i = 1; i <= cycles; i++) begin
            @(negedge clk);
            chk(stb == ((p > 0) && (i % p == 0)), req, $sformatf("strobe cycle %0d", i),
                int'(stb), int'((p > 0) && (i % p == 0)));
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [6:0]  c;
        logic [7:0]  d;
        logic [7:0]  d2;
        int          p;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        chk(rd_data == 16'h0000, "R1", "read word", int'(rd_data), 0);
        chk(buf_b == 8'h00, "R1", "buffer", int'(buf_b), 0);
        chk(err == 1'b0, "R1", "err", int'(err), 0);
        chk(stb == 1'b0, "R1", "strobe", int'(stb), 0);

        // R2 / R8 all ones
        write_word(16'hFFFF);
        chk(rd_data == 16'hFEFF, "R2", "bit8 masked", int'(rd_data), 16'hFEFF);
        chk(buf_b == 8'hFF, "R8", "buffer", int'(buf_b), 8'hFF);

        // random legal codes, unrestricted mode
        for (int it = 0; it < 20; it++) begin
            c = 7'($urandom);
            d = 8'($urandom);
            d2 = 8'($urandom);
            mode = (it % 2 == 0) ? 2'b00 : 2'b11;
            write_word({c, 1'($urandom), d});
            chk(rd_data == exp_read(c, d, 1'b0), "R5", "disabled readback",
                int'(rd_data), int'(exp_read(c, d, 1'b0)));
            chk(rd_data[8] == 1'b0, "R2", "bit8", int'(rd_data[8]), 0);
            chan_en = 1'b1;
            p = exp_period(int'(c), mode);
            watch(p, 2 * p, "R3/R9");
            @(negedge clk);
            write_word({~c, 1'b1, d2});
            chk(rd_data == exp_read(c, d2, 1'b1), "R7", "enabled read",
                int'(rd_data), int'(exp_read(c, d2, 1'b1)));
            chk(buf_b == d2, "R8", "buffer while enabled", int'(buf_b), int'(d2));
            chan_en = 1'b0;
            @(negedge clk);
            chk(rd_data == exp_read(c, d2, 1'b0), "R6", "code kept",
                int'(rd_data), int'(exp_read(c, d2, 1'b0)));
        end
        chk(err == 1'b0, "R10", "no error on legal codes", int'(err), 0);

        // edges of the code range
        write_word({7'd127, 1'b0, 8'h5A});
        chan_en = 1'b1;
        watch(256, 256, "R3");
        chan_en = 1'b0;
        write_word({7'd0, 1'b0, 8'h5A});
        chan_en = 1'b1;
        watch(2, 8, "R3");
        chan_en = 1'b0;

        // R4 external clock selected
        write_word({7'd3, 1'b0, 8'h11});
        clk_sel = 1'b1;
        chan_en = 1'b1;
        watch(0, 20, "R4");
        chan_en = 1'b0;
        clk_sel = 1'b0;

        // R10 UART code 0
        do_reset();
        mode = 2'b01;
        chan_en = 1'b1;
        @(negedge clk);
        chk(err == 1'b1, "R10", "uart code0 err", int'(err), 1);
        chan_en = 1'b0;
        @(negedge clk);
        chan_en = 1'b1;
        watch(6, 12, "R10");
        chan_en = 1'b0;
        chk(err == 1'b1, "R10", "err sticky", int'(err), 1);

        // R10 UART code 1
        do_reset();
        write_word({7'd1, 1'b0, 8'h00});
        mode = 2'b01;
        chan_en = 1'b1;
        watch(6, 12, "R10");
        chk(err == 1'b1, "R10", "uart code1 err", int'(err), 1);
        chan_en = 1'b0;

        // R10 I2C code 0 and code 1
        do_reset();
        mode = 2'b10;
        write_word({7'd1, 1'b0, 8'h00});
        chan_en = 1'b1;
        watch(4, 8, "R10");
        chk(err == 1'b0, "R10", "i2c code1 legal", int'(err), 0);
        chan_en = 1'b0;
        write_word({7'd0, 1'b0, 8'h00});
        chan_en = 1'b1;
        watch(4, 8, "R10");
        chk(err == 1'b1, "R10", "i2c code0 err", int'(err), 1);
        chan_en = 1'b0;

        // R11 mode change mid period
        do_reset();
        mode = 2'b01;
        chan_en = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            chk(stb == (i == 6 || i == 8 || i == 10), "R11",
                $sformatf("strobe cycle %0d", i), int'(stb),
                int'(i == 6 || i == 8 || i == 10));
            if (i == 3) mode = 2'b00;
        end
        chan_en = 1'b0;

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule